// File: doc/BRIEF.md
# Multiframe Q-channel nibble exchanger

This block moves the 4-bit maintenance nibble that a basic-rate S/T loop carries once per multiframe, in both directions. A host places an outgoing nibble in a read/write register. At every multiframe boundary the block takes a snapshot of that register and sends the snapshot one bit per carrying frame, most significant bit first. The carrying frames are the boundary frame and every fifth frame after it. If the host has not rewritten the register, the same nibble goes out again.

In the receive direction the block gathers the bits found in the same carrying frames. When the fourth bit arrives it publishes the completed nibble in a read-only register. Two interrupt sources share one level output: one fires at the start of each multiframe, and one fires, on the network side only, when a completed nibble differs from the one held before.

Frame alignment and the multiframe search are done elsewhere and arrive as one-cycle frame and multiframe strobes. The `nt_mode` input selects network-side or terminal-side behaviour.

Top module: `qnib_xchg`

## Requirements
- R1: Register address 0 holds the outgoing nibble in data bits 7:4, with bit 7 as its most significant bit. Writes load bits 7:4, and reads return the nibble with bits 3:0 equal to 0.
- R2: A hardware reset (`rst`) or a soft reset (a write to address 2 with bit 7 set) returns the block to its reset state. The outgoing nibble becomes 0x0 when `nt_mode`=1 and 0xF when `nt_mode`=0. The control register, the incoming nibble and the status register become 0, and `tx_bit` becomes 1.
- R3: The outgoing nibble is sampled only when a frame strobe arrives together with a multiframe strobe. A write made during a multiframe does not change the bits sent in that multiframe. A nibble that has not been rewritten is sent again in every following multiframe.
- R4: While multiframing is enabled, `tx_bit` updates on the clock edge of each frame strobe. In frames 0, 5, 10 and 15 of the multiframe it carries bits 3, 2, 1 and 0 of the snapshot, in that order. In every other frame it is 1.
- R5: Multiframing is enabled by bit 0 of the control register at address 2. While that bit is 0, `tx_bit` is 1 and the incoming nibble is not updated.
- R6: In frames 0, 5, 10 and 15, `rx_bit` is sampled, most significant bit first. The completed nibble appears in bits 7:4 of address 1 (bits 3:0 read 0) only after frame 15. Address 1 ignores writes.
- R7: When control bit 1 is set, status bit 0 at address 3 is set at each multiframe start while multiframing is enabled.
- R8: When control bit 2 is set and `nt_mode`=1, status bit 1 is set when a completed incoming nibble differs from the previously held nibble. In terminal-side mode it is never set.
- R9: `irq` is 1 whenever any status bit is set. A read of address 3 returns the status and clears it in the same clock edge, unless a new event arrives in that edge.
- R10: Addresses 4 to 7 read as 0xFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nt_mode | input | 1 | 1 selects network-side behaviour, 0 selects terminal-side behaviour |
| frm_stb | input | 1 | One-cycle pulse at each frame |
| mf_stb | input | 1 | High together with `frm_stb` on the first frame of a multiframe |
| rx_bit | input | 1 | Received Q/S bit of the current frame, valid with `frm_stb` |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered, valid the cycle after `host_re` |
| tx_bit | output | 1 | Transmitted Q/S bit of the current frame |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The assertions assume the following about the inputs:
- `mf_stb` only counts when `frm_stb` is high.
- Frame strobes are single-cycle pulses.
- `host_we` and `host_re` are never high in the same cycle.
- `nt_mode` changes only while reset is held.

The stimulus keeps to these rules. Every strobe is a one-cycle pulse separated by idle cycles, host accesses fall in the gaps between frames, and the mode is switched only under `rst`. Each multiframe is driven as exactly 20 frames that open with a boundary strobe, so the fixed bit positions in R4 and R6 hold for every multiframe.

// File: rtl/qnib_pkg.sv
package qnib_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_TXN = 3'd0;
  localparam addr_t A_RXN = 3'd1;
  localparam addr_t A_CTL = 3'd2;
  localparam addr_t A_STA = 3'd3;

  localparam int CB_EN    = 0;
  localparam int CB_EVERY = 1;
  localparam int CB_CHG   = 2;
  localparam int CB_SRST  = DATA_W - 1;

  localparam int SB_MF  = 0;
  localparam int SB_NEW = 1;
  localparam int STAT_W = 2;
endpackage

// File: rtl/qnib_slot_seq.sv
module qnib_slot_seq #(
  parameter int NIB_W   = 4,
  parameter int SLOT_SP = 5,
  localparam int SW   = (NIB_W > 1) ? $clog2(NIB_W) : 1,
  localparam int SUBW = (SLOT_SP > 1) ? $clog2(SLOT_SP) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          frm_stb,
  input  logic          mf_stb,
  output logic          mf_start,
  output logic          tick,
  output logic [SW-1:0] slot_idx
);
  logic [SUBW-1:0] sub_q, sub_d;
  logic [SW-1:0]   slot_q, slot_d;
  logic            act_q, act_d;

  assign mf_start = frm_stb & mf_stb;

  always_comb begin
    sub_d  = sub_q;
    slot_d = slot_q;
    act_d  = act_q;
    if (mf_start) begin
      sub_d  = '0;
      slot_d = '0;
      act_d  = 1'b1;
    end else if (frm_stb) begin
      if (sub_q == SUBW'(SLOT_SP - 1)) begin
        sub_d  = '0;
        slot_d = slot_q + 1'b1;
        act_d  = act_q && (slot_q != SW'(NIB_W - 1));
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  assign tick     = frm_stb && act_d && (sub_d == '0);
  assign slot_idx = slot_d;

  always_ff @(posedge clk) begin
    if (clr) begin
      sub_q  <= '0;
      slot_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sub_q  <= sub_d;
      slot_q <= slot_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/qnib_tx_ser.sv
module qnib_tx_ser #(
  parameter int NIB_W = 4,
  localparam int SW = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic             frm_stb,
  input  logic             tick,
  input  logic [SW-1:0]    slot_idx,
  input  logic [NIB_W-1:0] tx_nib,
  output logic             tx_bit
);
  logic [NIB_W-1:0] shadow_q;
  logic             pick;

  always_comb begin
    pick = 1'b1;
    for (int k = 0; k < NIB_W; k++) begin
      if (slot_idx == SW'(k)) pick = shadow_q[NIB_W-1-k];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      shadow_q <= '0;
      tx_bit   <= 1'b1;
    end else if (!en) begin
      tx_bit <= 1'b1;
    end else if (tick) begin
      if (slot_idx == '0) begin
        shadow_q <= tx_nib;
        tx_bit   <= tx_nib[NIB_W-1];
      end else begin
        tx_bit <= pick;
      end
    end else if (frm_stb) begin
      tx_bit <= 1'b1;
    end
  end
endmodule

// File: rtl/qnib_rx_des.sv
module qnib_rx_des #(
  parameter int NIB_W = 4,
  localparam int SW = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [SW-1:0]    slot_idx,
  input  logic             rx_bit,
  output logic [NIB_W-1:0] rx_nib,
  output logic             done,
  output logic             changed
);
  logic [NIB_W-2:0] sh_q;
  logic [NIB_W-1:0] full;

  assign full    = {sh_q, rx_bit};
  assign done    = en && tick && (slot_idx == SW'(NIB_W - 1));
  assign changed = (full != rx_nib);

  always_ff @(posedge clk) begin
    if (clr) begin
      sh_q   <= '0;
      rx_nib <= '0;
    end else if (en && tick) begin
      sh_q <= full[NIB_W-2:0];
      if (done) rx_nib <= full;
    end
  end
endmodule

// File: rtl/qnib_regs.sv
module qnib_regs
  import qnib_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nt_mode,
  input  logic                host_we,
  input  logic                host_re,
  input  addr_t               host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic                mf_start,
  input  logic                rx_done,
  input  logic                rx_chg,
  input  logic [NIB_W-1:0]    rx_nib,
  output logic                clr,
  output logic [NIB_W-1:0]    tx_nib,
  output logic                mf_en,
  output logic                stat_set,
  output logic [STAT_W-1:0]   stat_q,
  output logic                irq
);
  localparam int PAD = DATA_W - NIB_W;

  logic ctl_every, ctl_chg;
  logic srst, rd_clr, set_mf, set_new;
  logic [DATA_W-1:0] rd_val;
  logic unused_wbits;

  assign unused_wbits = ^host_wdata[CB_SRST-1:CB_CHG+1];

  assign srst     = host_we && (host_addr == A_CTL) && host_wdata[CB_SRST];
  assign clr      = rst | srst;
  assign rd_clr   = host_re && (host_addr == A_STA);
  assign set_mf   = mf_start && mf_en && ctl_every;
  assign set_new  = rx_done && rx_chg && nt_mode && ctl_chg;
  assign stat_set = set_mf | set_new;
  assign irq      = |stat_q;

  always_comb begin
    rd_val = '1;
    case (host_addr)
      A_TXN: rd_val = {tx_nib, {PAD{1'b0}}};
      A_RXN: rd_val = {rx_nib, {PAD{1'b0}}};
      A_CTL: rd_val = {{(DATA_W-3){1'b0}}, ctl_chg, ctl_every, mf_en};
      A_STA: rd_val = {{(DATA_W-STAT_W){1'b0}}, stat_q};
      default: rd_val = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      tx_nib    <= nt_mode ? '0 : '1;
      mf_en     <= 1'b0;
      ctl_every <= 1'b0;
      ctl_chg   <= 1'b0;
      stat_q    <= '0;
    end else begin
      if (host_we && host_addr == A_TXN) tx_nib <= host_wdata[DATA_W-1 -: NIB_W];
      if (host_we && host_addr == A_CTL) begin
        mf_en     <= host_wdata[CB_EN];
        ctl_every <= host_wdata[CB_EVERY];
        ctl_chg   <= host_wdata[CB_CHG];
      end
      stat_q[SB_MF]  <= (stat_q[SB_MF]  & ~rd_clr) | set_mf;
      stat_q[SB_NEW] <= (stat_q[SB_NEW] & ~rd_clr) | set_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_re) host_rdata <= rd_val;
  end
endmodule

// File: rtl/qnib_xchg.sv
module qnib_xchg
  import qnib_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int SLOT_SP = 5,
  localparam int SW = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        nt_mode,
  input  logic        frm_stb,
  input  logic        mf_stb,
  input  logic        rx_bit,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        tx_bit,
  output logic        irq
);
  logic              clr, mf_en, mf_start, tick, rx_done, rx_chg, stat_set;
  logic [SW-1:0]     slot_idx;
  logic [NIB_W-1:0]  tx_nib, rx_nib;
  logic [STAT_W-1:0] stat_q;

  qnib_regs #(.NIB_W(NIB_W)) u_regs (
    .clk(clk), .rst(rst), .nt_mode(nt_mode),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mf_start(mf_start), .rx_done(rx_done), .rx_chg(rx_chg), .rx_nib(rx_nib),
    .clr(clr), .tx_nib(tx_nib), .mf_en(mf_en), .stat_set(stat_set),
    .stat_q(stat_q), .irq(irq)
  );

  qnib_slot_seq #(.NIB_W(NIB_W), .SLOT_SP(SLOT_SP)) u_seq (
    .clk(clk), .clr(clr), .frm_stb(frm_stb), .mf_stb(mf_stb),
    .mf_start(mf_start), .tick(tick), .slot_idx(slot_idx)
  );

  qnib_tx_ser #(.NIB_W(NIB_W)) u_tx (
    .clk(clk), .clr(clr), .en(mf_en), .frm_stb(frm_stb), .tick(tick),
    .slot_idx(slot_idx), .tx_nib(tx_nib), .tx_bit(tx_bit)
  );

  qnib_rx_des #(.NIB_W(NIB_W)) u_rx (
    .clk(clk), .clr(clr), .en(mf_en), .tick(tick), .slot_idx(slot_idx),
    .rx_bit(rx_bit), .rx_nib(rx_nib), .done(rx_done), .changed(rx_chg)
  );
endmodule

// File: rtl/qnib_xchg_chk.sv
module qnib_xchg_chk
  import qnib_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              nt_mode,
  input logic              frm_stb,
  input logic              host_re,
  input logic              host_we,
  input logic [2:0]        host_addr,
  input logic [7:0]        host_rdata,
  input logic              tx_bit,
  input logic              irq,
  input logic              mf_en,
  input logic              tick,
  input logic              rx_done,
  input logic [NIB_W-1:0]  rx_nib,
  input logic [NIB_W-1:0]  tx_nib,
  input logic              stat_set,
  input logic [STAT_W-1:0] stat_q
);
  AST_TX_REG_HOLD: assert property (@(posedge clk) disable iff (clr)
    !(host_we && host_addr == A_TXN) |=> $stable(tx_nib)); // R1
  AST_TX_GAP_ONE: assert property (@(posedge clk) disable iff (clr)
    (frm_stb && !tick) |=> tx_bit); // R4
  AST_TX_IDLE_OFF: assert property (@(posedge clk) disable iff (clr)
    !mf_en |=> tx_bit); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (clr)
    !rx_done |=> $stable(rx_nib)); // R6
  AST_TE_NO_CHG: assert property (@(posedge clk) disable iff (clr)
    (!nt_mode && !stat_q[SB_NEW]) |=> !stat_q[SB_NEW]); // R8
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (clr)
    (host_re && host_addr == A_STA && !stat_set) |=> !irq); // R9
  AST_UNUSED_FF: assert property (@(posedge clk) disable iff (rst)
    (host_re && host_addr > A_STA) |=> host_rdata == 8'hFF); // R10
endmodule

bind qnib_xchg qnib_xchg_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .nt_mode(nt_mode), .frm_stb(frm_stb),
  .host_re(host_re), .host_we(host_we), .host_addr(host_addr),
  .host_rdata(host_rdata), .tx_bit(tx_bit), .irq(irq), .mf_en(mf_en),
  .tick(tick), .rx_done(rx_done), .rx_nib(rx_nib), .tx_nib(tx_nib),
  .stat_set(stat_set), .stat_q(stat_q)
);

// File: tb/qnib_xchg_tb.sv
module qnib_xchg_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1, nt_mode = 1, frm_stb = 0, mf_stb = 0, rx_bit = 0;
  logic host_we = 0, host_re = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic tx_bit, irq;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_tag = "R4";
  logic exp_q[$];
  logic frm_d = 0;

  always #(CLK_P/2) clk = ~clk;

  qnib_xchg u_dut (
    .clk(clk), .rst(rst), .nt_mode(nt_mode), .frm_stb(frm_stb), .mf_stb(mf_stb),
    .rx_bit(rx_bit), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_bit(tx_bit), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of transmitted bits
  always @(posedge clk) frm_d <= frm_stb;
  always @(negedge clk) begin
    if (frm_d) begin
      if (exp_q.size() == 0) chk({cur_tag, " tx queue empty"}, 8'(tx_bit), 8'hEE);
      else chk({cur_tag, " tx_bit"}, 8'(tx_bit), 8'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1; host_addr = a;
    @(negedge clk); host_re = 0; d = host_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic frame(input logic mf, input logic rb, input logic exp);
    @(negedge clk); frm_stb = 1; mf_stb = mf; rx_bit = rb; exp_q.push_back(exp);
    @(negedge clk); frm_stb = 0; mf_stb = 0; rx_bit = 0;
    @(negedge clk);
  endtask

  // driver: one multiframe of 20 frames; optional host write after frame wr_at
  task automatic run_mf(input logic [3:0] txn, input logic [3:0] rxn, input logic en,
                        input int wr_at, input logic [7:0] wr_val);
    for (int i = 0; i < 20; i++) begin
      logic carry, b, rb;
      carry = (i % 5 == 0) && (i < 20);
      b  = (carry && en) ? txn[3 - i/5] : 1'b1;
      rb = carry ? rxn[3 - i/5] : ~rxn[0];
      frame(i == 0, rb, b);
      if (i == wr_at) wr(3'd0, wr_val);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 irq after reset", 8'(irq), 8'h00);
    chk("R2 tx_bit after reset", 8'(tx_bit), 8'h01);
    rd_chk("R2 NT tx nibble reset", 3'd0, 8'h00);
    rd_chk("R6 rx nibble reset", 3'd1, 8'h00);

    wr(3'd0, 8'hA5);
    rd_chk("R1 tx nibble rw", 3'd0, 8'hA0);

    wr(3'd2, 8'h01);
    cur_tag = "R4";
    run_mf(4'hA, 4'h6, 1, -1, 8'h00);
    rd_chk("R6 rx nibble", 3'd1, 8'h60);

    cur_tag = "R3";
    run_mf(4'hA, 4'h9, 1, 7, 8'h30);
    run_mf(4'h3, 4'h9, 1, -1, 8'h00);
    run_mf(4'h3, 4'h9, 1, -1, 8'h00);
    rd_chk("R6 rx nibble second", 3'd1, 8'h90);
    wr(3'd1, 8'h00);
    rd_chk("R6 rx read-only", 3'd1, 8'h90);

    wr(3'd5, 8'h12);
    rd_chk("R10 unused addr 5", 3'd5, 8'hFF);
    rd_chk("R10 unused addr 7", 3'd7, 8'hFF);
    rd_chk("R10 tx untouched", 3'd0, 8'h30);

    wr(3'd2, 8'h00);
    cur_tag = "R5";
    run_mf(4'h3, 4'h5, 0, -1, 8'h00);
    rd_chk("R5 rx held when disabled", 3'd1, 8'h90);

    wr(3'd2, 8'h03);
    chk("R7 irq before boundary", 8'(irq), 8'h00);
    cur_tag = "R4";
    run_mf(4'h3, 4'h9, 1, -1, 8'h00);
    chk("R7 irq every multiframe", 8'(irq), 8'h01);
    rd_chk("R9 status read", 3'd3, 8'h01);
    chk("R9 irq cleared", 8'(irq), 8'h00);
    rd_chk("R9 status cleared", 3'd3, 8'h00);

    wr(3'd2, 8'h05);
    run_mf(4'h3, 4'h9, 1, -1, 8'h00);
    chk("R8 no irq on same nibble", 8'(irq), 8'h00);
    run_mf(4'h3, 4'hC, 1, -1, 8'h00);
    chk("R8 irq on new nibble", 8'(irq), 8'h01);
    rd_chk("R8 status new bit", 3'd3, 8'h02);
    chk("R9 irq cleared after read", 8'(irq), 8'h00);

    wr(3'd2, 8'h80);
    rd_chk("R2 soft reset tx NT", 3'd0, 8'h00);
    rd_chk("R2 soft reset ctrl", 3'd2, 8'h00);
    rd_chk("R2 soft reset rx", 3'd1, 8'h00);

    @(negedge clk); rst = 1; nt_mode = 0;
    repeat (3) @(negedge clk); rst = 0;
    rd_chk("R2 TE tx nibble reset", 3'd0, 8'hF0);
    wr(3'd2, 8'h05);
    cur_tag = "R4";
    run_mf(4'hF, 4'h3, 1, -1, 8'h00);
    run_mf(4'hF, 4'hA, 1, -1, 8'h00);
    rd_chk("R6 TE rx nibble", 3'd1, 8'hA0);
    chk("R8 TE no change irq", 8'(irq), 8'h00);
    rd_chk("R8 TE status", 3'd3, 8'h00);
    wr(3'd0, 8'h20);
    wr(3'd2, 8'h80);
    rd_chk("R2 TE soft reset tx", 3'd0, 8'hF0);

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule